// File: doc/BRIEF.md
# Locked-Pattern Fixed-Priority Arbiter

This block shares one resource among three requesters, each of which uses a four-phase request/grant handshake. While the resource is idle, the first clock edge that sees any request raises a lock and copies every pending request into a pattern register. The fixed priority function then looks only at that frozen copy and raises one grant. Channel 0 wins over channel 1, and channel 1 wins over channel 2.

A request that arrives after the lock cannot change the current round, even when its priority is higher. It waits. The grant stays high for as long as the winning request stays high. When that request drops, the grant falls on the next edge and the lock clears one edge after that. The arbiter then samples again, so every request that built up during the round competes in a fresh round. A late request with higher priority can therefore overtake one that has waited longer.

Top module: `locked_prio_arbiter`

## Requirements
- R1: A synchronous active-high reset `rst` leaves `grant` all zero and `locked` low, and it also clears the latched pattern.
- R2: At most one bit of `grant` is high in any cycle.
- R3: While `locked` is low, a clock edge that samples any `req` bit high raises `locked`, latches the whole `req` vector, and raises a grant, all at that same edge.
- R4: The grant goes to the lowest-numbered channel set in the latched pattern: bit 0 over bit 1, bit 1 over bit 2.
- R5: While the granted channel keeps its request high, `grant` does not change, whatever the other `req` bits do.
- R6: The edge that samples the granted channel's request low drives `grant` to zero while `locked` stays high. The next edge drives `locked` low.
- R7: After `locked` falls, the next edge that sees any request starts a new round over all pending requests. A higher-priority channel that arrived during the previous round beats an earlier waiter.
- R8: A channel whose request was low at the locking edge is not granted in that round.
- R9: While `locked` is low and no request is present, `locked` and `grant` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_CH (3) | Request per channel, bit index = channel number |
| grant | output | NUM_CH (3) | One-hot grant per channel |
| locked | output | 1 | High from the locking edge until the round is released |

## Verification
Every result comes out of a single register stage. The lock and the grant appear at the first edge that samples a request while the arbiter is idle. The grant drops at the edge that samples the winner's request low, and the lock falls one edge after that. A behavioural model in the bench steps on each rising edge, using the request value the bench drove half a cycle earlier. The bench compares both outputs with this model on every falling edge, when the design is settled. On top of that comparison, scenario checks at fixed cycle offsets cover: a request that arrives late, an overtake by a higher-priority channel, and the two-edge release.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_RELEASE = 2'd2
  } arbState_t;

  typedef struct packed {
    logic capture;   // copy live requests into the pattern
    logic clearPat;  // round over, wipe the pattern
    logic grantEn;   // pattern may drive the grant
  } ctrlStrobes_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import prio_arb_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] grant,
  input  logic              winnerActive,
  output ctrlStrobes_t      strobes,
  output logic              locked
);
  arbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (|req) begin
          strobes.capture = 1'b1;
          stateD = ST_HOLD;
        end
      end
      ST_HOLD: begin
        strobes.grantEn = 1'b1;
        if (!winnerActive) stateD = ST_RELEASE;
      end
      ST_RELEASE: begin
        strobes.clearPat = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign locked = (stateQ != ST_IDLE);

  // R3: any request seen while unlocked starts a round with a grant
  a_r3_lock_on_request: assert property (@(posedge clk) disable iff (rst)
    (!locked && |req) |=> (locked && |grant));

  // R9: nothing requested, nothing locked
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!locked && !(|req)) |=> (!locked && grant == '0));

  // R6: winner dropped -> grant gone, lock still held
  a_r6_grant_drop: assert property (@(posedge clk) disable iff (rst)
    (|grant && !(|(grant & req))) |=> (grant == '0 && locked));

  // R6: lock held with no grant clears on the following edge
  a_r6_unlock: assert property (@(posedge clk) disable iff (rst)
    (locked && grant == '0) |=> !locked);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import prio_arb_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  ctrlStrobes_t      strobes,
  output logic [NUM_CH-1:0] grant,
  output logic              winnerActive
);
  logic [NUM_CH-1:0] patternQ;
  logic [NUM_CH-1:0] pick;

  always_ff @(posedge clk) begin
    if (rst)                   patternQ <= '0;
    else if (strobes.capture)  patternQ <= req;
    else if (strobes.clearPat) patternQ <= '0;
  end

  // fixed priority: a channel wins only if no lower index is set
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign pick[i] = patternQ[i];
    end else begin : g_rest
      assign pick[i] = patternQ[i] & ~(|patternQ[i-1:0]);
    end
  end

  assign grant = strobes.grantEn ? pick : '0;
  assign winnerActive = |(grant & req);

  // R2: one-hot grant
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R5: grant frozen while the winner keeps requesting
  a_r5_grant_stable: assert property (@(posedge clk) disable iff (rst)
    (|(grant & req)) |=> (grant == $past(grant)));
endmodule

// File: rtl/locked_prio_arbiter.sv
module locked_prio_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] grant,
  output logic              locked
);
  ctrlStrobes_t strobes;
  logic         winnerActive;

  arb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .grant        (grant),
    .winnerActive (winnerActive),
    .strobes      (strobes),
    .locked       (locked)
  );

  arb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .strobes      (strobes),
    .grant        (grant),
    .winnerActive (winnerActive)
  );
endmodule

// File: tb/locked_prio_arbiter_test.sv
module locked_prio_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = 3'b000;
  logic [2:0] grant;
  logic       locked;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string curTag = "R1";

  // behavioural reference
  int         mPhase = 0;     // 0 free, 1 granted, 2 releasing
  logic [2:0] mPat = 3'b000;

  always #5 clk = ~clk;

  locked_prio_arbiter uut (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .locked(locked)
  );

  function automatic logic [2:0] lowestOf(input logic [2:0] v);
    for (int k = 0; k < 3; k++) if (v[k]) return 3'(1 << k);
    return 3'b000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mPat = 3'b000;
    end else begin
      case (mPhase)
        0: if (req != 0) begin mPat = req; mPhase = 1; end
        1: if ((lowestOf(mPat) & req) == 0) mPhase = 2;
        default: begin mPat = 3'b000; mPhase = 0; end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [2:0] eg;
    logic el;
    cycles++;
    eg = (mPhase == 1) ? lowestOf(mPat) : 3'b000;
    el = (mPhase != 0);
    checks++;
    if (grant !== eg || locked !== el) begin
      failures++;
      $display("FAIL %s model: grant=%b locked=%b expected grant=%b locked=%b",
               curTag, grant, locked, eg, el);
    end
    checks++;
    if ($countones(grant) > 1) begin  // R2
      failures++;
      $display("FAIL R2 onehot: grant=%b expected at most one bit", grant);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expect_out(input string tag, input logic [2:0] eg, input logic el);
    checks++;
    if (grant !== eg || locked !== el) begin
      failures++;
      $display("FAIL %s: grant=%b locked=%b expected grant=%b locked=%b",
               tag, grant, locked, eg, el);
    end
  endtask

  // set request, then wait to the following falling edge (one rising edge passes)
  task automatic step(input logic [2:0] r);
    req = r;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    expect_out("R1 reset", 3'b000, 1'b0);
    rst = 1'b0;

    curTag = "R9";
    step(3'b000); step(3'b000);
    expect_out("R9 idle", 3'b000, 1'b0);

    curTag = "R4";
    step(3'b110);
    expect_out("R3 lock at first edge", 3'b010, 1'b1);
    expect_out("R4 ch1 over ch2", 3'b010, 1'b1);
    step(3'b110);
    curTag = "R6";
    step(3'b100);
    expect_out("R6 grant falls lock held", 3'b000, 1'b1);
    step(3'b100);
    expect_out("R6 lock clears", 3'b000, 1'b0);
    curTag = "R7";
    step(3'b100);
    expect_out("R7 waiter recaptured", 3'b100, 1'b1);
    step(3'b000);
    step(3'b000);
    expect_out("R6 back to free", 3'b000, 1'b0);

    curTag = "R5";
    step(3'b100);
    expect_out("R3 ch2 alone", 3'b100, 1'b1);
    step(3'b110);
    expect_out("R5 late ch1 ignored", 3'b100, 1'b1);
    step(3'b111);
    expect_out("R8 late ch0 not granted", 3'b100, 1'b1);
    curTag = "R7";
    step(3'b011);
    expect_out("R6 release", 3'b000, 1'b1);
    step(3'b011);
    step(3'b011);
    expect_out("R7 ch0 overtakes ch1", 3'b001, 1'b1);
    step(3'b010);
    step(3'b010);
    step(3'b010);
    expect_out("R7 ch1 finally served", 3'b010, 1'b1);
    step(3'b000); step(3'b000);

    curTag = "R4";
    step(3'b111);
    expect_out("R4 ch0 over all", 3'b001, 1'b1);
    step(3'b101);
    expect_out("R5 other drop ignored", 3'b001, 1'b1);
    step(3'b000); step(3'b000);

    curTag = "R1";
    step(3'b010);
    expect_out("R3 ch1 lock", 3'b010, 1'b1);
    rst = 1'b1;
    step(3'b010);
    expect_out("R1 reset mid-round", 3'b000, 1'b0);
    rst = 1'b0;
    step(3'b000); step(3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule